// File: doc/BRIEF.md
# UART Transmitter with Break and Address Flag

This block serializes queued commands onto an asynchronous UART transmit line. Each data command is sent as one frame. The frame has a low start bit, then 5 to 8 data bits with the least significant bit first. An optional address-flag bit and an optional parity bit can follow the data. After that come a configurable number of high stop bits and an optional run of extra idle bit times between frames. A break command goes through the same queue, in order with the data. It holds the line low for a length carried in the command, then ends with the same stop and gap time as a data frame.

A small FIFO accepts commands. The framer takes the head entry only at a frame boundary, only while the clear-to-send input is high, and only then latches the line configuration for that frame. A baud-tick strobe sets the bit timing: each bit lasts a fixed number of strobes. When the address flag is enabled, multidrop receivers can tell address frames from data frames by that bit.

Top module: `utx_top`

## Requirements
- R1: After reset `tx` is 1, `busy` is 0 and `full` is 0. The line stays at 1 whenever no frame or break is in progress.
- R2: A data frame starts with one low bit. The data bits follow with the least significant bit first. `cfg_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Every bit lasts 16 baud ticks.
- R3: When `cfg_addr_en` is 1, the entry's `wr_addr` value is sent as one extra bit directly after the data bits.
- R4: `cfg_par` selects the parity bit: 0 none, 1 even, 2 odd, 3 none. The parity covers the data bits, plus the address bit when that bit is enabled. The parity bit is sent after the address bit, or directly after the data bits when there is no address bit.
- R5: Each frame or break ends with `cfg_stop`+1 high stop bits.
- R6: After the stop bits, `cfg_gap` extra high bit times pass before the next entry can start.
- R7: An entry written with `wr_kind`=1 is a break. It holds `tx` low for `wr_data`+1 bit times, then sends the stop and gap time. Breaks and data frames leave in the order they were written.
- R8: An entry starts only when `cts` is 1 at a frame boundary. Lowering `cts` during a frame or break does not shorten it.
- R9: The FIFO holds DEPTH entries (4 by default). `full` is 1 when it holds DEPTH entries. A write while full is ignored and is never sent.
- R10: During a frame, `tx` changes only on a clock edge where `baud_tick` was 1.
- R11: The configuration inputs are sampled when an entry starts. They stay in force for that whole entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Baud strobe; 16 strobes make one bit time |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity select: 0 none, 1 even, 2 odd, 3 none |
| cfg_addr_en | input | 1 | Enables the address-flag bit |
| cfg_stop | input | 2 | Stop bits minus 1 |
| cfg_gap | input | 4 | Extra idle bit times after the stop bits |
| wr_en | input | 1 | Writes one entry into the FIFO |
| wr_kind | input | 1 | 0 data frame, 1 break |
| wr_addr | input | 1 | Address-flag value for a data entry |
| wr_data | input | 8 | Data byte, or break length minus 1 |
| cts | input | 1 | Clear to send; gates the start of an entry |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame or break is in progress |
| full | output | 1 | FIFO holds DEPTH entries |

## Verification
The assertions check the following on every cycle: the line is idle high outside a frame, every frame opens with a low level, an entry starts only after `cts` was high, no entry starts while `cts` is low, line changes inside a frame fall on baud strobes, and `full` rises only after a write. The bench scenarios are the only way to show the bit order, parity values, address placement, stop and gap lengths, break length and its queue order, and that a write to a full FIFO is discarded. A cycle-accurate behavioural model in the bench compares `tx`, `busy` and `full` against the design on every clock for those scenarios.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_W = 8;
    localparam int BRK_W  = 8;
    localparam int STOP_W = 2;
    localparam int GAP_W  = 4;
    localparam int CNT_W  = BRK_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PAR,
        ST_STOP,
        ST_GAP,
        ST_BRK
    } utx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } utx_par_e;

    typedef struct packed {
        logic              is_brk;
        logic              addr;
        logic [DATA_W-1:0] data;
    } utx_entry_t;

    typedef struct packed {
        logic [1:0]        wlen;
        logic [1:0]        par;
        logic              addr_on;
        logic [STOP_W-1:0] stop;
        logic [GAP_W-1:0]  gap;
    } utx_cfg_t;

    // Mask of the active data bits for a word-length code (0 -> 5 bits).
    function automatic logic [DATA_W-1:0] wlen_mask(input logic [1:0] w);
        return {DATA_W{1'b1}} >> (3'd3 - {1'b0, w});
    endfunction

    function automatic logic par_enabled(input logic [1:0] p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Parity bit over the data bits and the optional address flag.
    function automatic logic par_bit(input logic [DATA_W-1:0] d,
                                     input logic [1:0] w,
                                     input logic addr_on,
                                     input logic addr,
                                     input logic [1:0] p);
        return (^(d & wlen_mask(w))) ^ (addr_on & addr) ^ (p == PAR_ODD);
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo
    import utx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  utx_entry_t push_entry,
    input  logic       pop,
    output utx_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W_F = $clog2(DEPTH + 1);

    utx_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W_F-1:0] count;
    logic               do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W_F'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_entry;
        end
    end
endmodule

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

    logic [SUB_W-1:0] sub;

    assign bit_end = run && tick && (sub == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub <= '0;
        end else if (tick) begin
            sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
        end
    end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  utx_cfg_t   cfg,
    input  utx_entry_t head,
    input  logic       empty,
    input  logic       cts,
    input  logic       bit_end,
    output logic       pop,
    output logic       busy,
    output logic       tx
);
    utx_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              addr_q, par_q;
    utx_cfg_t          cfg_q;

    assign pop  = (state == ST_IDLE) && !empty && cts;
    assign busy = (state != ST_IDLE);

    always_comb begin
        unique case (state)
            ST_START, ST_BRK: tx = 1'b0;
            ST_DATA:          tx = shreg[0];
            ST_ADDR:          tx = addr_q;
            ST_PAR:           tx = par_q;
            default:          tx = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            addr_q <= 1'b0;
            par_q  <= 1'b0;
            cfg_q  <= '0;
        end else if (state == ST_IDLE) begin
            if (pop) begin
                cfg_q  <= cfg;
                shreg  <= head.data;
                addr_q <= head.addr;
                par_q  <= par_bit(head.data, cfg.wlen, cfg.addr_on, head.addr, cfg.par);
                if (head.is_brk) begin
                    state <= ST_BRK;
                    cnt   <= CNT_W'(head.data);
                end else begin
                    state <= ST_START;
                end
            end
        end else if (bit_end) begin
            unique case (state)
                ST_START: begin
                    state <= ST_DATA;
                    cnt   <= CNT_W'(cfg_q.wlen) + CNT_W'(4);
                end
                ST_DATA: begin
                    if (cnt != '0) begin
                        cnt   <= cnt - 1'b1;
                        shreg <= shreg >> 1;
                    end else if (cfg_q.addr_on) begin
                        state <= ST_ADDR;
                    end else if (par_enabled(cfg_q.par)) begin
                        state <= ST_PAR;
                    end else begin
                        state <= ST_STOP;
                        cnt   <= CNT_W'(cfg_q.stop);
                    end
                end
                ST_ADDR: begin
                    if (par_enabled(cfg_q.par)) begin
                        state <= ST_PAR;
                    end else begin
                        state <= ST_STOP;
                        cnt   <= CNT_W'(cfg_q.stop);
                    end
                end
                ST_PAR: begin
                    state <= ST_STOP;
                    cnt   <= CNT_W'(cfg_q.stop);
                end
                ST_BRK: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= ST_STOP;
                        cnt   <= CNT_W'(cfg_q.stop);
                    end
                end
                ST_STOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (cfg_q.gap != '0) begin
                        state <= ST_GAP;
                        cnt   <= CNT_W'(cfg_q.gap) - 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/utx_top.sv
module utx_top
    import utx_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic [1:0]           cfg_wlen,
    input  logic [1:0]           cfg_par,
    input  logic                 cfg_addr_en,
    input  logic [STOP_W-1:0]    cfg_stop,
    input  logic [GAP_W-1:0]     cfg_gap,
    input  logic                 wr_en,
    input  logic                 wr_kind,
    input  logic                 wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 cts,
    output logic                 tx,
    output logic                 busy,
    output logic                 full
);
    utx_entry_t in_entry, head;
    utx_cfg_t   cfg;
    logic       empty, pop, bit_end;

    assign in_entry = '{is_brk: wr_kind, addr: wr_addr, data: wr_data};
    assign cfg      = '{wlen: cfg_wlen, par: cfg_par, addr_on: cfg_addr_en,
                        stop: cfg_stop, gap: cfg_gap};

    utx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_en),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .full       (full)
    );

    utx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    utx_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .head    (head),
        .empty   (empty),
        .cts     (cts),
        .bit_end (bit_end),
        .pop     (pop),
        .busy    (busy),
        .tx      (tx)
    );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic cts,
    input logic wr_en,
    input logic tx,
    input logic busy,
    input logic full
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    assert_cts_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cts));

    assert_no_start_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cts) |=> !busy);

    assert_tick_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(tx)) |-> $past(baud_tick));

    assert_full_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(wr_en));
endmodule

bind utx_top utx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .cts       (cts),
    .wr_en     (wr_en),
    .tx        (tx),
    .busy      (busy),
    .full      (full)
);

// File: tb/utx_top_tb.sv
module utx_top_tb;
    localparam int DEPTH = 4;
    localparam int TPB   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_addr_en = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic [3:0] cfg_gap = 4'd0;
    logic       wr_en = 1'b0;
    logic       wr_kind = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       cts = 1'b1;
    logic       tx, busy, full;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    utx_top #(.DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cfg_wlen(cfg_wlen), .cfg_par(cfg_par), .cfg_addr_en(cfg_addr_en),
        .cfg_stop(cfg_stop), .cfg_gap(cfg_gap),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .cts(cts), .tx(tx), .busy(busy), .full(full)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit    mq_kind[$];
    bit    mq_addr[$];
    bit [7:0] mq_data[$];
    bit    lv[$];
    string tg[$];
    bit    m_busy = 0;
    int    m_sub = 0;

    task automatic add_bits(input bit v, input int n, input string t);
        for (int i = 0; i < n; i++) begin
            lv.push_back(v);
            tg.push_back(t);
        end
    endtask

    // Builds the level sequence of one entry from the requirements.
    task automatic build_entry(input bit kind, input bit a, input bit [7:0] d);
        int nbits;
        bit p;
        if (kind) begin
            add_bits(1'b0, int'(d) + 1, "R7");
        end else begin
            nbits = 5 + int'(cfg_wlen);
            add_bits(1'b0, 1, "R2");
            p = 1'b0;
            for (int i = 0; i < nbits; i++) begin
                add_bits(d[i], 1, "R2");
                p ^= d[i];
            end
            if (cfg_addr_en) begin
                add_bits(a, 1, "R3");
                p ^= a;
            end
            if (cfg_par == 2'd1) add_bits(p, 1, "R4");
            if (cfg_par == 2'd2) add_bits(!p, 1, "R4");
        end
        add_bits(1'b1, int'(cfg_stop) + 1, "R5");
        add_bits(1'b1, int'(cfg_gap), "R6");
    endtask

    always @(posedge clk) begin
        int pre_size;
        cyc++;
        if (rst) begin
            mq_kind.delete(); mq_addr.delete(); mq_data.delete();
            lv.delete(); tg.delete();
            m_busy = 0;
            m_sub = 0;
        end else begin
            pre_size = mq_kind.size();
            if (m_busy) begin
                if (baud_tick) begin
                    m_sub++;
                    if (m_sub == TPB) begin
                        m_sub = 0;
                        lv.pop_front();
                        tg.pop_front();
                        if (lv.size() == 0) m_busy = 0;
                    end
                end
            end else if (pre_size > 0 && cts) begin
                build_entry(mq_kind[0], mq_addr[0], mq_data[0]);
                mq_kind.pop_front(); mq_addr.pop_front(); mq_data.pop_front();
                m_busy = 1;
                m_sub = 0;
            end
            if (wr_en && pre_size < DEPTH) begin
                mq_kind.push_back(wr_kind);
                mq_addr.push_back(wr_addr);
                mq_data.push_back(wr_data);
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        bit    e_tx;
        bit    e_full;
        string t;
        if (!rst) begin
            e_tx   = m_busy ? lv[0] : 1'b1;
            e_full = (mq_kind.size() == DEPTH);
            if (m_busy) t = (m_sub != 0) ? {tg[0], "/R10/R11"} : tg[0];
            else t = (mq_kind.size() > 0 && !cts) ? "R8" : "R1";
            compared++;
            if (tx !== e_tx || busy !== m_busy) begin
                mismatched++;
                $display("FAIL %s cyc=%0d tx=%b busy=%b expected tx=%b busy=%b",
                         t, cyc, tx, busy, e_tx, m_busy);
            end
            compared++;
            if (full !== e_full) begin
                mismatched++;
                $display("FAIL R9 cyc=%0d full=%b expected %b", cyc, full, e_full);
            end
        end
    end

    // baud strobe: two of every three clocks
    always @(negedge clk) baud_tick <= (cyc % 3) != 2;

    // ---------------- stimulus ----------------
    task automatic push(input bit kind, input bit a, input bit [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_kind = kind; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (m_busy || mq_kind.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(input bit [1:0] w, input bit [1:0] p, input bit ae,
                           input bit [1:0] s, input bit [3:0] g);
        cfg_wlen = w; cfg_par = p; cfg_addr_en = ae; cfg_stop = s; cfg_gap = g;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        repeat (5) @(negedge clk);   // R1 reset/idle state compared each clock
        #1;
        // R2 plain 8-bit frames
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0, 4'd0);
        push(0, 0, 8'hA5);
        push(0, 0, 8'h3C);
        drain();
        // R4 5-bit even parity, 7-bit odd parity, reserved code
        set_cfg(2'd0, 2'd1, 1'b0, 2'd1, 4'd0);
        push(0, 0, 8'hF3);
        drain();
        set_cfg(2'd2, 2'd2, 1'b0, 2'd0, 4'd0);
        push(0, 0, 8'h55);
        drain();
        set_cfg(2'd1, 2'd3, 1'b0, 2'd0, 4'd0);
        push(0, 0, 8'h2B);
        drain();
        // R3 address bit with parity, R5 four stop bits, R6 gap
        set_cfg(2'd3, 2'd1, 1'b1, 2'd3, 4'd3);
        push(0, 1, 8'h81);
        push(0, 0, 8'h81);
        drain();
        // R7 break queued between data frames
        set_cfg(2'd3, 2'd2, 1'b0, 2'd1, 4'd2);
        push(0, 0, 8'h11);
        push(1, 0, 8'd12);
        push(0, 0, 8'hEE);
        push(1, 0, 8'd0);
        drain();
        // R8/R9 hold with cts low, fill FIFO, extra write dropped
        cts = 1'b0;
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0, 4'd1);
        push(0, 0, 8'h01);
        push(0, 0, 8'h02);
        push(0, 0, 8'h03);
        push(0, 0, 8'h04);
        push(0, 0, 8'hFF);
        repeat (60) @(negedge clk);
        #1 cts = 1'b1;
        // R11 config change while a frame is in flight
        while (!m_busy) @(negedge clk);
        #1 set_cfg(2'd0, 2'd1, 1'b1, 2'd2, 4'd0);
        // R8 drop cts mid-frame, frame must complete
        repeat (40) @(negedge clk);
        #1 cts = 1'b0;
        repeat (600) @(negedge clk);
        #1 cts = 1'b1;
        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not end, actual cyc=%0d expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule